// File: doc/BRIEF.md
# Duplicated ALU with Shift-Recompute Fault Location

This block is an 8-bit arithmetic and logic unit that is hardened against single bit flips in its combinational logic. Two identical copies of the ALU logic evaluate every operation on the same registered operands. When both copies agree, the shared answer is delivered at once. When they disagree, the block spends one extra cycle on a time-redundant self-check to find out which copy is wrong. Each copy runs the operation again with both operands shifted left by one bit. The block shifts that answer back right by one bit and compares it with the answer the same copy gave before. The copy whose two answers match is trusted, and its result is forwarded.

Operands enter through a valid/ready handshake together with a 3-bit opcode. Each answer comes out as a 9-bit result with a one-cycle valid pulse. Three flags come with it: a flag that says a disagreement was seen, a 2-bit code that names the faulty copy, and a flag for a fault that could not be resolved. The internal datapath is two bits wider than the operands, so neither the carry nor the shifted copy loses a top bit. For test, each copy has a fault selector on its raw output. The selector can leave one chosen bit untouched, force it to 0 or force it to 1.

Top module: `dup_recompute_alu`

## Requirements
- R1: A synchronous active-high reset clears resValid, result, errDetected, faultCopy and uncorrectable to zero and returns the block to idle with inReady high.
- R2: inReady is high only while the block is idle. An operation is accepted on a clock edge where inValid and inReady are both high, and inReady stays low from the next cycle until the cycle in which that operation's result is valid.
- R3: The result is 9 bits wide, with opcode 0 giving opA+opB (carry in bit 8), opcode 1 giving opA-opB modulo 512 (borrow in bit 8), opcode 2 bitwise AND, opcode 3 bitwise OR and opcode 4 bitwise XOR. Opcodes 2 to 4 have bit 8 at zero, and opcodes 5, 6 and 7 give zero.
- R4: When both copies agree, resValid rises two cycles after the accepting edge, with errDetected=0, faultCopy=00 and uncorrectable=0.
- R5: When the copies disagree, the result arrives one cycle later (three cycles after the accepting edge) with errDetected=1.
- R6: In the check, each copy recomputes on operands shifted left by one bit, and its answer shifted right by one bit is compared with its first answer. If only copy A passes, copy A's result is output with faultCopy=10 (copy B faulty). If only copy B passes, copy B's result is output with faultCopy=01 (copy A faulty).
- R7: If both copies fail the check, or both pass and still disagree, uncorrectable=1 and faultCopy=11, and copy A's first result is output.
- R8: Each copy's fault selector acts on the bit of its 10-bit raw output chosen by faultSel (0 to 9; values 10 to 15 touch no bit). The mode is 00 pass, 01 force 0, 10 force 1, 11 pass. A forced value equal to the true value raises no error.
- R9: resValid is a single-cycle pulse for each accepted operation. The result and flags hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand request valid |
| inReady | output | 1 | Block idle and able to accept |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| opCode | input | 3 | Operation select |
| faultModeA | input | 2 | Test fault mode for copy A |
| faultSelA | input | 4 | Test fault bit index for copy A |
| faultModeB | input | 2 | Test fault mode for copy B |
| faultSelB | input | 4 | Test fault bit index for copy B |
| resValid | output | 1 | Result valid pulse |
| result | output | 9 | Result with carry or borrow in bit 8 |
| errDetected | output | 1 | Copies disagreed on this operation |
| faultCopy | output | 2 | 00 none, 01 copy A, 10 copy B, 11 undetermined |
| uncorrectable | output | 1 | Check could not isolate a single faulty copy |

## Verification
The bench forces single bits in one copy at several positions. The low bit, a middle bit and the carry bit are all covered, so a design that compared the recomputed answer without shifting it back, or that dropped the top bit, would blame the healthy copy or forward a wrong sum. It injects faults into both copies at once, where a wrong design would still claim a single culprit instead of reporting an unresolved fault with copy A's value. It forces a bit to the value it already has, uses mode 11 and uses a selector index outside the output. A design that treated any armed fault as an error would then report a false disagreement and add latency. A long mixed run with randomly placed faults checks that the extra cycle is taken exactly when the copies disagree, so a design that stalled on every operation, or never stalled, shows the wrong arrival cycle.

// File: rtl/dra_pkg.sv
package dra_pkg;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  localparam logic [1:0] FM_ZERO = 2'b01;
  localparam logic [1:0] FM_ONE  = 2'b10;

  localparam logic [1:0] FC_NONE  = 2'b00;
  localparam logic [1:0] FC_A     = 2'b01;
  localparam logic [1:0] FC_B     = 2'b10;
  localparam logic [1:0] FC_UNRES = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_CHECK = 2'd2
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOps;
    logic shiftSel;
    logic holdResults;
    logic emitDirect;
    logic emitChecked;
  } dpCtrl_t;

endpackage

// File: rtl/dra_core.sv
// One copy of the combinational ALU with a test fault selector on its output.
module dra_core
  import dra_pkg::*;
#(
  parameter int CORE_W = 10,
  localparam int SEL_W = $clog2(CORE_W)
) (
  input  logic [CORE_W-1:0] x,
  input  logic [CORE_W-1:0] y,
  input  logic [2:0]        op,
  input  logic [1:0]        faultMode,
  input  logic [SEL_W-1:0]  faultSel,
  output logic [CORE_W-1:0] z
);

  logic [CORE_W-1:0] trueVal;

  always_comb begin
    case (op)
      OP_ADD:  trueVal = x + y;
      OP_SUB:  trueVal = x - y;
      OP_AND:  trueVal = x & y;
      OP_OR:   trueVal = x | y;
      OP_XOR:  trueVal = x ^ y;
      default: trueVal = '0;
    endcase
  end

  logic forceOn;
  logic forceVal;
  assign forceOn  = (faultMode == FM_ZERO) || (faultMode == FM_ONE);
  assign forceVal = (faultMode == FM_ONE);

  for (genvar i = 0; i < CORE_W; i++) begin : g_bit
    logic hit;
    assign hit  = forceOn && (faultSel == SEL_W'(i));
    assign z[i] = hit ? forceVal : trueVal[i];
  end

endmodule

// File: rtl/dra_datapath.sv
module dra_datapath
  import dra_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RES_W  = DATA_W + 1,
  localparam int CORE_W = DATA_W + 2,
  localparam int SEL_W  = $clog2(CORE_W),
  localparam int COPIES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic [2:0]        inOp,
  input  logic [1:0]        faultModeA,
  input  logic [SEL_W-1:0]  faultSelA,
  input  logic [1:0]        faultModeB,
  input  logic [SEL_W-1:0]  faultSelB,
  output logic              copiesAgree,
  output logic              resValid,
  output logic [RES_W-1:0]  result,
  output logic              errDetected,
  output logic [1:0]        faultCopy,
  output logic              uncorrectable
);

  logic [DATA_W-1:0] regA, regB;
  logic [2:0]        regOp;
  logic [RES_W-1:0]  heldA, heldB;

  logic [CORE_W-1:0] opX, opY;
  assign opX = ctrl.shiftSel ? {1'b0, regA, 1'b0} : {2'b00, regA};
  assign opY = ctrl.shiftSel ? {1'b0, regB, 1'b0} : {2'b00, regB};

  logic [1:0]        fMode [COPIES];
  logic [SEL_W-1:0]  fSel  [COPIES];
  logic [CORE_W-1:0] raw   [COPIES];

  assign fMode[0] = faultModeA;
  assign fMode[1] = faultModeB;
  assign fSel[0]  = faultSelA;
  assign fSel[1]  = faultSelB;

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    dra_core #(.CORE_W(CORE_W)) u_core (
      .x(opX),
      .y(opY),
      .op(regOp),
      .faultMode(fMode[g]),
      .faultSel(fSel[g]),
      .z(raw[g])
    );
  end

  logic passA, passB;
  assign copiesAgree = (raw[0][RES_W-1:0] == raw[1][RES_W-1:0]);
  assign passA = (raw[0][RES_W:1] == heldA);
  assign passB = (raw[1][RES_W:1] == heldB);

  always_ff @(posedge clk) begin
    if (rst) begin
      regA          <= '0;
      regB          <= '0;
      regOp         <= '0;
      heldA         <= '0;
      heldB         <= '0;
      resValid      <= 1'b0;
      result        <= '0;
      errDetected   <= 1'b0;
      faultCopy     <= FC_NONE;
      uncorrectable <= 1'b0;
    end else begin
      resValid <= ctrl.emitDirect | ctrl.emitChecked;
      if (ctrl.loadOps) begin
        regA  <= inA;
        regB  <= inB;
        regOp <= inOp;
      end
      if (ctrl.holdResults) begin
        heldA <= raw[0][RES_W-1:0];
        heldB <= raw[1][RES_W-1:0];
      end
      if (ctrl.emitDirect) begin
        result        <= raw[0][RES_W-1:0];
        errDetected   <= 1'b0;
        faultCopy     <= FC_NONE;
        uncorrectable <= 1'b0;
      end else if (ctrl.emitChecked) begin
        errDetected <= 1'b1;
        if (passA && !passB) begin
          result        <= heldA;
          faultCopy     <= FC_B;
          uncorrectable <= 1'b0;
        end else if (!passA && passB) begin
          result        <= heldB;
          faultCopy     <= FC_A;
          uncorrectable <= 1'b0;
        end else begin
          result        <= heldA;
          faultCopy     <= FC_UNRES;
          uncorrectable <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dra_control.sv
module dra_control
  import dra_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    copiesAgree,
  output logic    inReady,
  output dpCtrl_t ctrl
);

  state_e st, stNext;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= stNext;
  end

  always_comb begin
    stNext  = st;
    ctrl    = '0;
    inReady = 1'b0;
    case (st)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          ctrl.loadOps = 1'b1;
          stNext       = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (copiesAgree) begin
          ctrl.emitDirect = 1'b1;
          stNext          = ST_IDLE;
        end else begin
          ctrl.holdResults = 1'b1;
          stNext           = ST_CHECK;
        end
      end
      ST_CHECK: begin
        ctrl.shiftSel    = 1'b1;
        ctrl.emitChecked = 1'b1;
        stNext           = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dup_recompute_alu.sv
module dup_recompute_alu
  import dra_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RES_W  = DATA_W + 1,
  localparam int SEL_W  = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        opCode,
  input  logic [1:0]        faultModeA,
  input  logic [SEL_W-1:0]  faultSelA,
  input  logic [1:0]        faultModeB,
  input  logic [SEL_W-1:0]  faultSelB,
  output logic              resValid,
  output logic [RES_W-1:0]  result,
  output logic              errDetected,
  output logic [1:0]        faultCopy,
  output logic              uncorrectable
);

  dpCtrl_t ctrl;
  logic    copiesAgree;

  dra_control u_control (
    .clk(clk),
    .rst(rst),
    .inValid(inValid),
    .copiesAgree(copiesAgree),
    .inReady(inReady),
    .ctrl(ctrl)
  );

  dra_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk),
    .rst(rst),
    .ctrl(ctrl),
    .inA(opA),
    .inB(opB),
    .inOp(opCode),
    .faultModeA(faultModeA),
    .faultSelA(faultSelA),
    .faultModeB(faultModeB),
    .faultSelB(faultSelB),
    .copiesAgree(copiesAgree),
    .resValid(resValid),
    .result(result),
    .errDetected(errDetected),
    .faultCopy(faultCopy),
    .uncorrectable(uncorrectable)
  );

endmodule

// File: rtl/dra_checker.sv
module dra_checker #(
  parameter int RES_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             resValid,
  input logic [RES_W-1:0] result,
  input logic             errDetected,
  input logic [1:0]       faultCopy,
  input logic             uncorrectable
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!resValid && !errDetected && faultCopy == 2'b00 && !uncorrectable && result == '0));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);

  assert_direct_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (resValid && !errDetected) |-> ($past(!inReady) && $past(inReady, 2)));

  assert_clean_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (resValid && !errDetected) |-> (faultCopy == 2'b00 && !uncorrectable));

  assert_check_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (resValid && errDetected) |-> ($past(!inReady) && $past(!inReady, 2) && $past(inReady, 3)));

  assert_unresolved_code_R7: assert property (@(posedge clk) disable iff (rst)
    uncorrectable |-> (faultCopy == 2'b11 && errDetected));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    resValid |=> !resValid);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !resValid |-> $stable(result));

endmodule

bind dup_recompute_alu dra_checker #(.RES_W(DATA_W + 1)) u_checker (
  .clk(clk),
  .rst(rst),
  .inValid(inValid),
  .inReady(inReady),
  .resValid(resValid),
  .result(result),
  .errDetected(errDetected),
  .faultCopy(faultCopy),
  .uncorrectable(uncorrectable)
);

// File: tb/dup_recompute_alu_test.sv
module dup_recompute_alu_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       inValid;
  logic       inReady;
  logic [7:0] opA, opB;
  logic [2:0] opCode;
  logic [1:0] faultModeA, faultModeB;
  logic [3:0] faultSelA, faultSelB;
  logic       resValid;
  logic [8:0] result;
  logic       errDetected;
  logic [1:0] faultCopy;
  logic       uncorrectable;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dup_recompute_alu uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .opCode(opCode),
    .faultModeA(faultModeA), .faultSelA(faultSelA),
    .faultModeB(faultModeB), .faultSelB(faultSelB),
    .resValid(resValid), .result(result), .errDetected(errDetected),
    .faultCopy(faultCopy), .uncorrectable(uncorrectable)
  );

  typedef struct {
    logic [8:0] res;
    logic       err;
    logic [1:0] fc;
    logic       unc;
    int         lat;
    int         accCyc;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   fails  = 0;
  int   cycCnt = 0;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // reference: one ALU copy on the widened operands (R3), optional shift (R6)
  function automatic logic [9:0] aluRef(input logic [7:0] a, input logic [7:0] b,
                                        input logic [2:0] op, input bit sh);
    logic [9:0] x, y;
    x = sh ? {1'b0, a, 1'b0} : {2'b00, a};
    y = sh ? {1'b0, b, 1'b0} : {2'b00, b};
    case (op)
      3'd0:    return x + y;
      3'd1:    return x - y;
      3'd2:    return x & y;
      3'd3:    return x | y;
      3'd4:    return x ^ y;
      default: return 10'd0;
    endcase
  endfunction

  // fault selector per R8
  function automatic logic [9:0] inject(input logic [9:0] v, input logic [1:0] m, input int s);
    logic [9:0] r;
    r = v;
    if (s < 10) begin
      if (m == 2'b01) r[s] = 1'b0;
      else if (m == 2'b10) r[s] = 1'b1;
    end
    return r;
  endfunction

  function automatic exp_t model(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                                 input logic [1:0] mA, input int sA,
                                 input logic [1:0] mB, input int sB, input string tag);
    exp_t e;
    logic [8:0] ua, ub, da, db;
    logic [9:0] t;
    t  = inject(aluRef(a, b, op, 1'b0), mA, sA); ua = t[8:0];
    t  = inject(aluRef(a, b, op, 1'b0), mB, sB); ub = t[8:0];
    e.tag = tag;
    if (ua == ub) begin
      e.res = ua; e.err = 1'b0; e.fc = 2'b00; e.unc = 1'b0; e.lat = 2;
    end else begin
      t  = inject(aluRef(a, b, op, 1'b1), mA, sA); da = t[9:1];
      t  = inject(aluRef(a, b, op, 1'b1), mB, sB); db = t[9:1];
      e.err = 1'b1; e.lat = 3;
      if (da == ua && db != ub) begin
        e.res = ua; e.fc = 2'b10; e.unc = 1'b0;
      end else if (da != ua && db == ub) begin
        e.res = ub; e.fc = 2'b01; e.unc = 1'b0;
      end else begin
        e.res = ua; e.fc = 2'b11; e.unc = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic doOp(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                      input logic [1:0] mA, input int sA,
                      input logic [1:0] mB, input int sB, input string tag);
    exp_t e;
    @(posedge clk); #1;
    opA = a; opB = b; opCode = op;
    faultModeA = mA; faultSelA = 4'(sA);
    faultModeB = mB; faultSelB = 4'(sB);
    inValid = 1'b1;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    e = model(a, b, op, mA, sA, mB, sB, tag);
    e.accCyc = cycCnt;
    sbq.push_back(e);
    @(posedge clk); #1;
    inValid = 1'b0;
    @(negedge clk);
    check(inReady == 1'b0, "R2 ready low while busy", int'(inReady), 0);
    while (!inReady) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every result pulse
  always @(negedge clk) begin
    if (!rst && resValid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R9 result pulse with nothing pending", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(result == e.res, {e.tag, " result"}, int'(result), int'(e.res));
        check(errDetected == e.err, "R5 errDetected", int'(errDetected), int'(e.err));
        check(faultCopy == e.fc, "R6 faultCopy", int'(faultCopy), int'(e.fc));
        check(uncorrectable == e.unc, "R7 uncorrectable", int'(uncorrectable), int'(e.unc));
        check(cycCnt - e.accCyc == e.lat, (e.lat == 2) ? "R4 latency" : "R5 latency",
              cycCnt - e.accCyc, e.lat);
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", cycCnt, 0);
    finishRun();
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; opA = '0; opB = '0; opCode = '0;
    faultModeA = '0; faultSelA = '0; faultModeB = '0; faultSelB = '0;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!resValid && result == 9'd0 && !errDetected && faultCopy == 2'b00 && !uncorrectable,
          "R1 outputs after reset", int'({resValid, errDetected, faultCopy, uncorrectable}), 0);
    check(inReady == 1'b1, "R2 ready when idle", int'(inReady), 1);

    // R3: functions without faults
    doOp(8'd200, 8'd100, 3'd0, 2'b00, 0, 2'b00, 0, "R3 add carry");
    doOp(8'd5,   8'd9,   3'd1, 2'b00, 0, 2'b00, 0, "R3 sub borrow");
    doOp(8'hF0,  8'h3C,  3'd2, 2'b00, 0, 2'b00, 0, "R3 and");
    doOp(8'hF0,  8'h3C,  3'd3, 2'b00, 0, 2'b00, 0, "R3 or");
    doOp(8'hF0,  8'h3C,  3'd4, 2'b00, 0, 2'b00, 0, "R3 xor");
    doOp(8'hAA,  8'h55,  3'd6, 2'b00, 0, 2'b00, 0, "R3 unused opcode");

    // R6: single copy faults at low, middle and carry positions
    doOp(8'd3, 8'd4, 3'd0, 2'b10, 3, 2'b00, 0, "R6 copy A bit3 force1");
    doOp(8'd3, 8'd4, 3'd0, 2'b00, 0, 2'b01, 0, "R6 copy B bit0 force0");
    doOp(8'd3, 8'd4, 3'd0, 2'b00, 0, 2'b10, 8, "R6 copy B carry force1");
    doOp(8'd9, 8'd2, 3'd4, 2'b01, 0, 2'b00, 0, "R6 copy A xor bit0");

    // R7: both copies faulty
    doOp(8'd3, 8'd4, 3'd0, 2'b10, 3, 2'b10, 5, "R7 both copies faulty");

    // R1: reset mid-run clears error flags
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!errDetected && faultCopy == 2'b00 && !uncorrectable && result == 9'd0,
          "R1 flags cleared by reset", int'({errDetected, faultCopy, uncorrectable}), 0);

    // R8: harmless selector settings
    doOp(8'd3, 8'd4, 3'd0, 2'b10, 0,  2'b00, 0, "R8 force equal to true");
    doOp(8'd3, 8'd4, 3'd0, 2'b11, 0,  2'b11, 1, "R8 mode 11 passes");
    doOp(8'd3, 8'd4, 3'd0, 2'b10, 12, 2'b01, 15, "R8 index out of range");

    // mixed run with random operands and faults
    for (int i = 0; i < 300; i++) begin
      logic [1:0] mA, mB;
      int sA, sB, sc;
      sc = int'($urandom % 4);
      mA = (sc == 1 || sc == 3) ? 2'($urandom % 4) : 2'b00;
      mB = (sc == 2 || sc == 3) ? 2'($urandom % 4) : 2'b00;
      sA = int'($urandom % 10);
      sB = int'($urandom % 10);
      doOp(8'($urandom), 8'($urandom), 3'($urandom % 8), mA, sA, mB, sB, "R6 random mix");
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sbq.size() == 0, "R9 results outstanding at end", sbq.size(), 0);
    finishRun();
  end

endmodule